// File: doc/BRIEF.md
# Fuse Block Read Controller

This controller sits between a simple register bus and a one-time-programmable fuse array. Software chooses one of 32 sixteen-bit blocks through an index register and issues a read command. It then watches a status word until a sticky completion flag appears, picks up the block contents from a read-data register, and clears the flag with a separate command bit. The fuse side uses a level request with a block address. The array answers with a one-cycle valid pulse that carries the data.

A module enable input gates the whole controller. While it is low, any read in flight is dropped, the request to the array falls, the completion flag is cleared and the bus sees neither writes nor read data. A protect input appears in the status word as a read-only flag. The global-control, write-data, write-timing, read-timing and debounce registers are plain 32-bit storage. Burning fuses is not implemented: the program-start command bit has no effect and the program-busy flag always reads zero.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: Offsets 0x00, 0x08, 0x20, 0x24 and 0x28 each store a full 32-bit write and read it back unchanged. The command offset 0x10 and every unmapped offset (for example 0x18) read as zero.
- R2: The block index at offset 0x0C keeps only write-data bits [4:0]. Its upper bits read as zero.
- R3: A write to 0x10 with bit 1 set while standby is reported starts a read. From the next cycle `fa_req` is high and `fa_blk` carries the index that was current at launch. `fa_blk` stays fixed while the read runs, even if the index register is rewritten.
- R4: A read-start written while a read is busy is ignored. After that read completes, no second request follows.
- R5: The status word at 0x14 has program busy in bit 0 (always 0), read busy in bit 1, standby in bit 2, protect in bit 3 and read done in bit 4. While enabled, standby is the inverse of read busy.
- R6: On the clock edge where `fa_vld` is sampled high during a read, read busy falls, standby and read done rise, and offset 0x04 returns `fa_data` in bits [15:0] with zeros above. Done then stays set without further action.
- R7: A write to 0x10 with bit 2 set clears read done. Bit 0 (program start) changes nothing. A single write with both bits 1 and 2 set clears done and starts a read.
- R8: Status bit 3 follows `prot_in`. Writes to the status offset change nothing.
- R9: While `mod_en` is low, the read in flight is abandoned (`fa_req` low from the next cycle), done is cleared, bus writes are discarded and `bus_rdata` is zero. A `fa_vld` pulse arriving while no read is busy is ignored, and the read data is kept.
- R10: After reset every register reads zero, and status reads 0x04 while enabled.
- R11: When a clear-done write lands on the same edge as array completion, the completion wins and done reads as set afterwards.
- R12: `bus_rdata` is zero whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_en | input | 1 | Module enable; low forces idle |
| prot_in | input | 1 | Protect level shown in status bit 3 |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_rd | input | 1 | Read enable for the combinational read path |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| fa_blk | output | 5 | Block index presented to the fuse array |
| fa_req | output | 1 | Read request, held high until completion |
| fa_vld | input | 1 | One-cycle completion pulse from the array |
| fa_data | input | 16 | Block contents, valid with `fa_vld` |

## Verification
Two things can meet on one clock edge: the array's completion pulse and a clear-done command from software. The bench provokes this by setting the array model's latency so that its valid pulse falls on the same edge that samples a clear write, then reads status and expects done to be set and busy clear. A second overlap combines clear and start in one command write while done is set. Here the expected result is done cleared and a new read busy. A behavioural model updated on every edge judges all register reads and the array request in between.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

    localparam int FR_AW     = 8;
    localparam int FR_DW     = 32;
    localparam int FR_BW     = 16;
    localparam int FR_IW     = 5;
    localparam int FR_NSTORE = 5;

    // Offsets decoded by the register bank
    localparam logic [FR_AW-1:0] OFF_RDAT = 8'h04;
    localparam logic [FR_AW-1:0] OFF_IDX  = 8'h0C;
    localparam logic [FR_AW-1:0] OFF_MODE = 8'h10;
    localparam logic [FR_AW-1:0] OFF_STAT = 8'h14;

    // Plain storage registers: global control, write data, two timing, debounce
    localparam logic [FR_AW-1:0] STORE_OFF [FR_NSTORE] =
        '{8'h00, 8'h08, 8'h20, 8'h24, 8'h28};

    // Command bit positions
    localparam int MB_RD  = 1;
    localparam int MB_CLR = 2;

    // Status bit positions
    localparam int SB_PBUSY = 0;
    localparam int SB_RBUSY = 1;
    localparam int SB_STBY  = 2;
    localparam int SB_PROT  = 3;
    localparam int SB_DONE  = 4;

    typedef enum logic {RS_IDLE, RS_BUSY} rd_state_e;

    typedef struct packed {
        logic start;
        logic clr;
    } fuse_cmd_t;

    typedef struct packed {
        logic done;
        logic prot;
        logic stby;
        logic rbusy;
    } fuse_sts_t;

    function automatic logic [FR_DW-1:0] pack_status(input fuse_sts_t s);
        logic [FR_DW-1:0] w;
        w           = '0;
        w[SB_PBUSY] = 1'b0;
        w[SB_RBUSY] = s.rbusy;
        w[SB_STBY]  = s.stby;
        w[SB_PROT]  = s.prot;
        w[SB_DONE]  = s.done;
        return w;
    endfunction

endpackage

// File: rtl/fuse_reg_bank.sv
module fuse_reg_bank
    import fuse_rd_pkg::*;
#(
    parameter int AW = FR_AW,
    parameter int DW = FR_DW,
    parameter int BW = FR_BW,
    parameter int IW = FR_IW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          rd,
    input  logic [DW-1:0] wdata,
    input  fuse_sts_t     sts,
    input  logic [BW-1:0] rd_word,
    output logic [IW-1:0] idx,
    output fuse_cmd_t     cmd,
    output logic [DW-1:0] rdata
);

    localparam int IDX_PAD = DW - IW;
    localparam int DAT_PAD = DW - BW;

    logic          wr_ok;
    logic [IW-1:0] idx_q;
    logic [DW-1:0] store_q [FR_NSTORE];

    assign wr_ok = wr && en;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (wr_ok && addr == OFF_IDX) begin
            idx_q <= wdata[IW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < FR_NSTORE; i++) begin
            if (rst) begin
                store_q[i] <= '0;
            end else if (wr_ok && addr == STORE_OFF[i]) begin
                store_q[i] <= wdata;
            end
        end
    end

    // Command bits are single-cycle pulses, never stored
    always_comb begin
        cmd.start = wr_ok && (addr == OFF_MODE) && wdata[MB_RD];
        cmd.clr   = wr_ok && (addr == OFF_MODE) && wdata[MB_CLR];
    end

    always_comb begin
        rdata = '0;
        if (rd && en) begin
            case (addr)
                OFF_RDAT: rdata = {{DAT_PAD{1'b0}}, rd_word};
                OFF_IDX:  rdata = {{IDX_PAD{1'b0}}, idx_q};
                OFF_STAT: rdata = pack_status(sts);
                default: begin
                    for (int i = 0; i < FR_NSTORE; i++) begin
                        if (addr == STORE_OFF[i]) rdata = store_q[i];
                    end
                end
            endcase
        end
    end

    assign idx = idx_q;

    AST_IDX_FROZEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(idx_q)); // R9

endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
    import fuse_rd_pkg::*;
#(
    parameter int BW = FR_BW,
    parameter int IW = FR_IW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  fuse_cmd_t     cmd,
    input  logic [IW-1:0] idx,
    input  logic          fa_vld,
    input  logic [BW-1:0] fa_data,
    output logic          fa_req,
    output logic [IW-1:0] fa_blk,
    output logic          busy,
    output logic          done,
    output logic [BW-1:0] rd_word
);

    rd_state_e     state_q;
    logic          done_q;
    logic [IW-1:0] blk_q;
    logic [BW-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RS_IDLE;
            done_q  <= 1'b0;
            blk_q   <= '0;
            data_q  <= '0;
        end else if (!en) begin
            state_q <= RS_IDLE;
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                RS_IDLE: begin
                    if (cmd.clr) done_q <= 1'b0;
                    if (cmd.start) begin
                        state_q <= RS_BUSY;
                        blk_q   <= idx;
                    end
                end
                RS_BUSY: begin
                    if (fa_vld) begin
                        state_q <= RS_IDLE;
                        done_q  <= 1'b1;
                        data_q  <= fa_data;
                    end else if (cmd.clr) begin
                        done_q <= 1'b0;
                    end
                end
                default: state_q <= RS_IDLE;
            endcase
        end
    end

    assign busy    = (state_q == RS_BUSY);
    assign fa_req  = busy;
    assign fa_blk  = blk_q;
    assign done    = done_q;
    assign rd_word = data_q;

    AST_REQ_DROPS_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> !fa_req); // R9
    AST_BLK_HELD: assert property (@(posedge clk) disable iff (rst)
        en && fa_req && !fa_vld |=> fa_req && $stable(fa_blk)); // R3
    AST_FINISH_WINS: assert property (@(posedge clk) disable iff (rst)
        en && fa_req && fa_vld |=> done && !fa_req); // R11
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        en && done && !cmd.clr |=> done); // R6

endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl
    import fuse_rd_pkg::*;
#(
    parameter int AW = FR_AW,
    parameter int DW = FR_DW,
    parameter int BW = FR_BW,
    parameter int IW = FR_IW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mod_en,
    input  logic          prot_in,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [IW-1:0] fa_blk,
    output logic          fa_req,
    input  logic          fa_vld,
    input  logic [BW-1:0] fa_data
);

    fuse_cmd_t     cmd;
    fuse_sts_t     sts;
    logic [IW-1:0] idx;
    logic          busy;
    logic          done;
    logic [BW-1:0] rd_word;

    always_comb begin
        sts.rbusy = busy;
        sts.stby  = mod_en && !busy;
        sts.prot  = prot_in;
        sts.done  = done;
    end

    fuse_reg_bank #(.AW(AW), .DW(DW), .BW(BW), .IW(IW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .en      (mod_en),
        .addr    (bus_addr),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .wdata   (bus_wdata),
        .sts     (sts),
        .rd_word (rd_word),
        .idx     (idx),
        .cmd     (cmd),
        .rdata   (bus_rdata)
    );

    fuse_rd_seq #(.BW(BW), .IW(IW)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .en      (mod_en),
        .cmd     (cmd),
        .idx     (idx),
        .fa_vld  (fa_vld),
        .fa_data (fa_data),
        .fa_req  (fa_req),
        .fa_blk  (fa_blk),
        .busy    (busy),
        .done    (done),
        .rd_word (rd_word)
    );

    AST_STANDBY_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        mod_en && busy && cmd.start && !fa_vld |=> fa_req && $stable(fa_blk)); // R4

endmodule

// File: tb/tb_fuse_rd_ctrl.sv
module tb_fuse_rd_ctrl;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        mod_en;
    logic        prot_in;
    logic [7:0]  bus_addr;
    logic        bus_wr;
    logic        bus_rd;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [4:0]  fa_blk;
    logic        fa_req;
    logic        fa_vld;
    logic [15:0] fa_data;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    fuse_rd_ctrl dut (
        .clk(clk), .rst(rst), .mod_en(mod_en), .prot_in(prot_in),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fa_blk(fa_blk), .fa_req(fa_req), .fa_vld(fa_vld), .fa_data(fa_data)
    );

    // ---------------- fuse array model ----------------
    int          lat = 1;
    int          cnt = 0;
    logic        arr_vld = 1'b0;
    logic [15:0] arr_data = '0;
    logic        stray = 1'b0;
    logic [15:0] stray_data = '0;

    function automatic logic [15:0] fuse_word(input logic [4:0] b);
        return 16'hC3A0 + 16'(b) * 16'h0111;
    endfunction

    always @(posedge clk) begin
        if (arr_vld) begin
            arr_vld <= 1'b0;
        end else if (fa_req) begin
            if (cnt >= lat) begin
                arr_vld  <= 1'b1;
                arr_data <= fuse_word(fa_blk);
                cnt      <= 0;
            end else begin
                cnt <= cnt + 1;
            end
        end else begin
            cnt <= 0;
        end
    end

    assign fa_vld  = arr_vld | stray;
    assign fa_data = stray ? stray_data : arr_data;

    // ---------------- reference model ----------------
    logic [31:0] m_reg [256];
    logic [4:0]  m_idx, m_blk;
    logic        m_busy, m_done;
    logic [15:0] m_data;
    logic        m_st, m_cl;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) m_reg[i] = '0;
            m_idx = '0; m_blk = '0; m_busy = 0; m_done = 0; m_data = '0;
        end else if (!mod_en) begin
            m_busy = 0;
            m_done = 0;
        end else begin
            m_st = 0;
            m_cl = 0;
            if (bus_wr) begin
                case (bus_addr)
                    8'h00, 8'h08, 8'h20, 8'h24, 8'h28: m_reg[bus_addr] = bus_wdata;
                    8'h0C: m_idx = bus_wdata[4:0];
                    8'h10: begin m_st = bus_wdata[1]; m_cl = bus_wdata[2]; end
                    default: ;
                endcase
            end
            if (m_busy) begin
                if (fa_vld) begin
                    m_busy = 0; m_done = 1; m_data = fa_data;
                end else if (m_cl) begin
                    m_done = 0;
                end
            end else begin
                if (m_cl) m_done = 0;
                if (m_st) begin m_busy = 1; m_blk = m_idx; end
            end
        end
    end

    function automatic logic [31:0] exp_rd();
        if (!bus_rd || !mod_en) return '0;
        case (bus_addr)
            8'h00, 8'h08, 8'h20, 8'h24, 8'h28: return m_reg[bus_addr];
            8'h04: return {16'h0, m_data};
            8'h0C: return {27'h0, m_idx};
            8'h14: return {27'h0, m_done, prot_in, !m_busy, m_busy, 1'b0};
            default: return '0;
        endcase
    endfunction

    function automatic string addr_tag(input logic [7:0] a);
        case (a)
            8'h14:   return "R5";
            8'h04:   return "R6";
            8'h0C:   return "R2";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk("R3", 32'(fa_req), 32'(m_busy));
            if (m_busy) chk("R3", 32'(fa_blk), 32'(m_blk));
            chk(addr_tag(bus_addr), bus_rdata, exp_rd());
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_wr = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_rd = 1; bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1; mod_en = 1; prot_in = 0;
        bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        #2 rst = 0;

        // R10: reset state
        rdchk("R10", 8'h14, 32'h4);
        rdchk("R10", 8'h0C, 32'h0);
        rdchk("R10", 8'h20, 32'h0);
        rdchk("R10", 8'h04, 32'h0);

        // R1: storage registers, command and unmapped offsets
        wr(8'h20, 32'hDEAD_BEEF);
        wr(8'h24, 32'h1234_5678);
        wr(8'h28, 32'h0000_00A5);
        wr(8'h00, 32'h8000_0001);
        wr(8'h08, 32'hFFFF_0000);
        rdchk("R1", 8'h20, 32'hDEAD_BEEF);
        rdchk("R1", 8'h24, 32'h1234_5678);
        rdchk("R1", 8'h28, 32'h0000_00A5);
        rdchk("R1", 8'h00, 32'h8000_0001);
        rdchk("R1", 8'h08, 32'hFFFF_0000);
        rdchk("R1", 8'h18, 32'h0);
        rdchk("R1", 8'h10, 32'h0);

        // R2: index keeps five bits
        wr(8'h0C, 32'hFFFF_FFE5);
        rdchk("R2", 8'h0C, 32'h5);

        // R12: no read enable, zero data
        bus_rd = 0; bus_addr = 8'h20; #1;
        chk("R12", bus_rdata, 32'h0);

        // R3/R5: launch a read of block 5
        lat = 1;
        wr(8'h10, 32'h2);
        chk("R3", 32'(fa_req), 32'h1);
        chk("R3", 32'(fa_blk), 32'h5);
        rdchk("R5", 8'h14, 32'h2);
        wr(8'h0C, 32'h7);
        chk("R3", 32'(fa_blk), 32'h5);
        // R4: start while busy is ignored
        wr(8'h10, 32'h2);
        idle(1);
        chk("R4", 32'(fa_req), 32'h0);
        idle(1);
        chk("R4", 32'(fa_req), 32'h0);
        // R6: completion and stickiness
        rdchk("R6", 8'h14, 32'h14);
        rdchk("R6", 8'h04, {16'h0, fuse_word(5'd5)});
        idle(5);
        rdchk("R6", 8'h14, 32'h14);

        // R7: program start has no effect, clear drops done
        wr(8'h10, 32'h1);
        rdchk("R7", 8'h14, 32'h14);
        chk("R7", 32'(fa_req), 32'h0);
        wr(8'h10, 32'h4);
        rdchk("R7", 8'h14, 32'h4);

        // R8: protect pin, status not writable
        prot_in = 1; #1;
        rdchk("R8", 8'h14, 32'hC);
        wr(8'h14, 32'h0);
        rdchk("R8", 8'h14, 32'hC);
        prot_in = 0;

        // R11: clear and completion on the same edge (index now 7)
        lat = 3;
        wr(8'h10, 32'h2);
        idle(4);
        wr(8'h10, 32'h4);
        rdchk("R11", 8'h14, 32'h14);
        rdchk("R11", 8'h04, {16'h0, fuse_word(5'd7)});

        // R7: clear and start in one write
        wr(8'h10, 32'h6);
        rdchk("R7", 8'h14, 32'h2);
        idle(6);
        rdchk("R7", 8'h14, 32'h14);
        wr(8'h10, 32'h4);

        // R9: disable during a read
        wr(8'h0C, 32'h3);
        wr(8'h10, 32'h2);
        mod_en = 0;
        idle(1);
        chk("R9", 32'(fa_req), 32'h0);
        rdchk("R9", 8'h14, 32'h0);
        wr(8'h20, 32'h0000_1234);
        mod_en = 1;
        idle(1);
        rdchk("R9", 8'h20, 32'hDEAD_BEEF);
        rdchk("R9", 8'h14, 32'h4);
        // R9: stray valid while idle is ignored
        stray_data = 16'h5555; stray = 1;
        idle(1);
        stray = 0;
        idle(1);
        rdchk("R9", 8'h14, 32'h4);
        rdchk("R9", 8'h04, {16'h0, fuse_word(5'd7)});
        // R9: disable clears a set done flag
        lat = 1;
        wr(8'h10, 32'h2);
        idle(4);
        rdchk("R9", 8'h14, 32'h14);
        mod_en = 0;
        idle(1);
        mod_en = 1;
        idle(1);
        rdchk("R9", 8'h14, 32'h4);
        rdchk("R9", 8'h04, {16'h0, fuse_word(5'd3)});

        idle(2);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule